// File: doc/BRIEF.md
# Preemptive Interrupt Priority CPU Interface

This block is the per-processor side of a small interrupt controller. It watches a set of `N` interrupt sources. Each source has a pending flag held inside the block, an enable input and an 8-bit priority input. A lower priority value means more urgent. Every cycle the block finds the most urgent pending and enabled source. It filters that source through a software priority mask and through the priority of the interrupt being serviced, and it drives a registered interrupt request line to the processor.

Software takes an interrupt by reading the acknowledge offset. That read returns the source ID, clears the source's pending flag and makes the source the running interrupt at its priority. Software retires an interrupt by writing its ID to the end-of-interrupt offset. Interrupts that preempt one another form a nesting chain, kept as one predecessor link per source. Retiring the running interrupt falls back to its predecessor. Retiring an interrupt further down the chain removes it from the chain and leaves the running interrupt in place.

ID 1023 means "no interrupt". While nothing is running, the running priority is 0x100, which is less urgent than any 8-bit priority.

Top module: `pic_cpu_if`

## Requirements
- R1: After reset the request line is low, the running priority reads 0x100, and both the highest-pending read and an acknowledge read return 1023.
- R2: The winner is the pending and enabled source with the numerically lowest priority. On equal priority the lowest ID wins.
- R3: A write to offset 0x04 sets the priority mask from bits 7:0 and reads back there. Offset 0x18 returns the winner's ID only when the winner's priority is strictly below the mask, and 1023 otherwise.
- R4: The request line is high exactly when a winner shows at offset 0x18 and its priority is also strictly below the running priority. The line reflects the block's state one cycle later.
- R5: The control offset 0x00 holds bit 0 (interface enable) and bit 1 (controller enable). If either bit is clear, the request line is low, offset 0x18 reads 1023 and an acknowledge returns 1023.
- R6: A read of offset 0x0C returns 1023 and changes nothing when no source qualifies for the request line. Otherwise it returns the winner's ID, clears that source's pending flag, and makes the source running at its priority, which offset 0x14 then returns as a 9-bit value.
- R7: A write to offset 0x10 takes the ID from bits 9:0. It is ignored when the ID is N or above, or when nothing is running.
- R8: Retiring the running interrupt makes its predecessor running, at the predecessor's current priority. If there is no predecessor, the block returns to ID 1023 and priority 0x100.
- R9: Retiring an interrupt that is in the chain but not running removes it from the chain and leaves the running interrupt and priority unchanged. Retiring an ID that is not in the chain has no effect.
- R10: A pulse on `irq_set[i]` sets the pending flag of source i. The flag stays set, even while the source is disabled, until an acknowledge takes the source.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd`. Offsets with no register read 0. A write presented in the same cycle as a read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_set | input | N | One-cycle pulses that set source pending flags |
| src_en | input | N | Per-source enable |
| src_prio | input | 8*N | Per-source priority; source i in bits 8i+7:8i |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a chain three or more deep in which an entry in the middle is retired before the running one. The stimulus can only get there if each new source is made pending with a priority strictly more urgent than the running one before it is acknowledged. The directed part builds such a chain on purpose, retires its middle entry, and then unwinds the chain with repeated and out-of-range end-of-interrupt writes. The random part freezes the priorities of sources in the chain, sends end-of-interrupt writes mostly to IDs taken from the bench's own copy of the chain, and so keeps reaching deep nesting and splices.

// File: rtl/pic_cpu_pkg.sv
`timescale 1ns/1ps
package pic_cpu_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int RP_W   = PRIO_W + 1;
  localparam logic [ID_W-1:0] NO_ID     = 10'd1023;
  localparam logic [RP_W-1:0] IDLE_PRIO = 9'h100;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MASK = 8'h04;
  localparam logic [7:0] OFS_ACK  = 8'h0C;
  localparam logic [7:0] OFS_EOI  = 8'h10;
  localparam logic [7:0] OFS_RUNP = 8'h14;
  localparam logic [7:0] OFS_HIGH = 8'h18;
endpackage

// File: rtl/pic_prio_select.sv
`timescale 1ns/1ps
module pic_prio_select
  import pic_cpu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]        pend,
  input  logic [N-1:0]        en,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                win_valid,
  output logic [ID_W-1:0]     win_id,
  output logic [PRIO_W-1:0]   win_prio
);
  // Ascending scan with a strict compare: on a tie the earlier (lower) ID stays.
  always_comb begin
    win_valid = 1'b0;
    win_id    = NO_ID;
    win_prio  = '1;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && en[i] && (!win_valid || (prio[i*PRIO_W +: PRIO_W] < win_prio))) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_prio  = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/pic_active_chain.sv
`timescale 1ns/1ps
module pic_active_chain
  import pic_cpu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_en,
  input  logic [ID_W-1:0]     push_id,
  input  logic [PRIO_W-1:0]   push_prio,
  input  logic                eoi_en,
  input  logic [ID_W-1:0]     eoi_id,
  input  logic [N*PRIO_W-1:0] prio,
  output logic [ID_W-1:0]     run_id,
  output logic [RP_W-1:0]     run_prio
);
  logic [ID_W-1:0] pred_q [N];
  logic [ID_W-1:0] pred_d [N];
  logic [ID_W-1:0] run_id_q, run_id_d;
  logic [RP_W-1:0] run_prio_q, run_prio_d;
  logic            eoi_ok, pop, splice;
  logic [ID_W-1:0] eoi_pred;
  logic [RP_W-1:0] eoi_pred_prio;

  assign eoi_ok = eoi_en && (eoi_id < ID_W'(N)) && (run_id_q != NO_ID);
  assign pop    = eoi_ok && (eoi_id == run_id_q);
  assign splice = eoi_ok && !pop;

  // Predecessor of the retired entry, and that predecessor's present priority.
  always_comb begin
    eoi_pred      = NO_ID;
    eoi_pred_prio = IDLE_PRIO;
    for (int i = 0; i < N; i++) begin
      if (eoi_id == ID_W'(i)) eoi_pred = pred_q[i];
    end
    for (int i = 0; i < N; i++) begin
      if (eoi_pred == ID_W'(i)) eoi_pred_prio = {1'b0, prio[i*PRIO_W +: PRIO_W]};
    end
  end

  // Links of retired entries return to NO_ID, so only chain members ever point
  // at another entry; the one link naming the retired ID is rewired in parallel.
  for (genvar g = 0; g < N; g++) begin : g_link
    always_comb begin
      pred_d[g] = pred_q[g];
      if (push_en && (push_id == ID_W'(g))) begin
        pred_d[g] = run_id_q;
      end else if (eoi_ok && (eoi_id == ID_W'(g))) begin
        pred_d[g] = NO_ID;
      end else if (splice && (pred_q[g] == eoi_id)) begin
        pred_d[g] = eoi_pred;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pred_q[g] <= NO_ID;
      end else begin
        pred_q[g] <= pred_d[g];
      end
    end
  end

  always_comb begin
    run_id_d   = run_id_q;
    run_prio_d = run_prio_q;
    if (push_en) begin
      run_id_d   = push_id;
      run_prio_d = {1'b0, push_prio};
    end else if (pop) begin
      run_id_d   = eoi_pred;
      run_prio_d = eoi_pred_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id_q   <= NO_ID;
      run_prio_q <= IDLE_PRIO;
    end else begin
      run_id_q   <= run_id_d;
      run_prio_q <= run_prio_d;
    end
  end

  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;
endmodule

// File: rtl/pic_cpu_if.sv
`timescale 1ns/1ps
module pic_cpu_if
  import pic_cpu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        irq_set,
  input  logic [N-1:0]        src_en,
  input  logic [N*PRIO_W-1:0] src_prio,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq_o
);
  logic [1:0]        ctrl_q, ctrl_d;
  logic [PRIO_W-1:0] mask_q, mask_d;
  logic [N-1:0]      pend_q, pend_d, ack_clr;
  logic [31:0]       rdata_q, rdata_d;
  logic              irq_q;
  logic              win_valid;
  logic [ID_W-1:0]   win_id;
  logic [PRIO_W-1:0] win_prio;
  logic [ID_W-1:0]   run_id;
  logic [RP_W-1:0]   run_prio;
  logic              if_on, hp_ok, ack_ok, ack_rd, ack_take, wr_eff, eoi_wr;
  logic [ID_W-1:0]   hp_id, eoi_id;
  logic              unused_wdata;

  pic_prio_select #(.N(N)) u_sel (
    .pend      (pend_q),
    .en        (src_en),
    .prio      (src_prio),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_prio  (win_prio)
  );

  assign if_on    = ctrl_q[0] && ctrl_q[1];
  assign hp_ok    = if_on && win_valid && (win_prio < mask_q);
  assign hp_id    = hp_ok ? win_id : NO_ID;
  assign ack_ok   = hp_ok && ({1'b0, win_prio} < run_prio);
  assign ack_rd   = reg_rd && (reg_addr == OFS_ACK);
  assign ack_take = ack_rd && ack_ok;
  assign wr_eff   = reg_wr && !reg_rd;
  assign eoi_wr   = wr_eff && (reg_addr == OFS_EOI);
  assign eoi_id   = reg_wdata[ID_W-1:0];
  assign unused_wdata = ^reg_wdata[31:ID_W];

  pic_active_chain #(.N(N)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (ack_take),
    .push_id   (win_id),
    .push_prio (win_prio),
    .eoi_en    (eoi_wr),
    .eoi_id    (eoi_id),
    .prio      (src_prio),
    .run_id    (run_id),
    .run_prio  (run_prio)
  );

  for (genvar g = 0; g < N; g++) begin : g_clr
    assign ack_clr[g] = ack_take && (win_id == ID_W'(g));
  end

  always_comb begin
    pend_d = (pend_q & ~ack_clr) | irq_set;
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    if (wr_eff && (reg_addr == OFS_CTRL)) ctrl_d = reg_wdata[1:0];
    if (wr_eff && (reg_addr == OFS_MASK)) mask_d = reg_wdata[PRIO_W-1:0];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) begin
      unique case (reg_addr)
        OFS_CTRL: rdata_d = {30'd0, ctrl_q};
        OFS_MASK: rdata_d = {24'd0, mask_q};
        OFS_ACK:  rdata_d = {22'd0, (ack_ok ? win_id : NO_ID)};
        OFS_RUNP: rdata_d = {23'd0, run_prio};
        OFS_HIGH: rdata_d = {22'd0, hp_id};
        default:  rdata_d = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 2'b00;
      mask_q  <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      mask_q  <= mask_d;
      pend_q  <= pend_d;
      rdata_q <= rdata_d;
      irq_q   <= ack_ok;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/pic_cpu_if_chk.sv
`timescale 1ns/1ps
module pic_cpu_if_chk
  import pic_cpu_pkg::*;
#(
  parameter int N = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic [1:0]      ctrl_q,
  input logic [ID_W-1:0] run_id,
  input logic [RP_W-1:0] run_prio,
  input logic [ID_W-1:0] hp_id,
  input logic            ack_rd,
  input logic            ack_ok,
  input logic            eoi_wr,
  input logic [ID_W-1:0] eoi_id
);
  AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == NO_ID) == (run_prio == IDLE_PRIO)); // R1

  AST_IRQ_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(hp_id) != NO_ID)); // R4

  AST_IRQ_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(ctrl_q) == 2'b11)); // R5

  AST_ACK_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && ack_ok) |=> (run_prio < $past(run_prio))); // R6

  AST_ACK_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !ack_ok) |=> ($stable(run_id) && $stable(run_prio))); // R6

  AST_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && ((eoi_id >= ID_W'(N)) || (run_id == NO_ID))) |=> ($stable(run_id) && $stable(run_prio))); // R7
endmodule

bind pic_cpu_if pic_cpu_if_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_o    (irq_o),
  .ctrl_q   (ctrl_q),
  .run_id   (run_id),
  .run_prio (run_prio),
  .hp_id    (hp_id),
  .ack_rd   (ack_rd),
  .ack_ok   (ack_ok),
  .eoi_wr   (eoi_wr),
  .eoi_id   (eoi_id)
);

// File: tb/sim_pic_cpu_if.sv
`timescale 1ns/1ps
module sim_pic_cpu_if;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_set;
  logic [N-1:0]  src_en;
  logic [N*8-1:0] src_prio;
  logic          reg_rd, reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          irq_o;

  always #2 clk = ~clk;

  pic_cpu_if #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .src_en(src_en), .src_prio(src_prio),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  bit [N-1:0] m_pend;
  int         m_ctrl, m_mask, m_rp;
  int         stk[$];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int pr(int i);
    return int'(src_prio[i*8 +: 8]);
  endfunction

  function automatic int m_best();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && src_en[i] && (w < 0 || pr(i) < pr(w))) w = i;
    return w;
  endfunction

  function automatic int m_high();
    int w = m_best();
    if (m_ctrl != 3 || w < 0) return 1023;
    if (pr(w) >= m_mask) return 1023;
    return w;
  endfunction

  function automatic int m_irq();
    int h = m_high();
    return (h != 1023 && pr(h) < m_rp) ? 1 : 0;
  endfunction

  function automatic bit in_stk(int id);
    foreach (stk[k]) if (stk[k] == id) return 1;
    return 0;
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic settle(string req);
    cyc();
    chk(req, int'(irq_o), m_irq());
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic do_ack(string req);
    int w, exp, got;
    w = m_high();
    exp = 1023;
    if (w != 1023 && pr(w) < m_rp) begin
      exp = w;
      m_pend[w] = 1'b0;
      stk.push_back(w);
      m_rp = pr(w);
    end
    rd(8'h0C, got);
    chk(req, got, exp);
    settle("R4");
  endtask

  task automatic do_eoi(int id, string req);
    int got;
    if (id < N && stk.size() > 0) begin
      if (stk[$] == id) begin
        void'(stk.pop_back());
        m_rp = (stk.size() == 0) ? 256 : pr(stk[$]);
      end else begin
        foreach (stk[k]) if (stk[k] == id) begin stk.delete(k); break; end
      end
    end
    wr(8'h10, 32'(id) | 32'hABCD_0000);
    rd(8'h14, got);
    chk(req, got, m_rp);
    settle("R4");
  endtask

  task automatic do_set(logic [N-1:0] v);
    irq_set = v;
    cyc();
    irq_set = '0;
    m_pend |= v;
    settle("R10");
  endtask

  task automatic check_high(string req);
    int got;
    rd(8'h18, got);
    chk(req, got, m_high());
  endtask

  task automatic set_prio(int i, int p);
    src_prio[i*8 +: 8] = 8'(p);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL R0 watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int got;
    rst_n = 1'b0; irq_set = '0; src_en = '1; reg_rd = 0; reg_wr = 0;
    reg_addr = 0; reg_wdata = 0;
    for (int i = 0; i < N; i++) set_prio(i, 8'h80);
    m_pend = '0; m_ctrl = 0; m_mask = 0; m_rp = 256;
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 irq", int'(irq_o), 0);
    rd(8'h18, got); chk("R1 high", got, 1023);
    rd(8'h14, got); chk("R1 runp", got, 256);
    rd(8'h0C, got); chk("R1 ack", got, 1023);
    // R11 unmapped offset, read latency
    rd(8'h20, got); chk("R11 unmapped", got, 0);
    // R3 mask write keeps low 8 bits
    wr(8'h04, 32'h1F0); m_mask = 8'hF0;
    rd(8'h04, got); chk("R3 mask", got, 8'hF0);
    // R11 write with simultaneous read dropped
    reg_wr = 1; reg_wdata = 32'h33; reg_rd = 1; reg_addr = 8'h04;
    cyc(); reg_wr = 0; reg_rd = 0;
    rd(8'h04, got); chk("R11 rdwr", got, 8'hF0);
    wr(8'h00, 32'h3); m_ctrl = 3;
    wr(8'h04, 32'hFF); m_mask = 8'hFF;
    // R2 tie goes to lower ID
    set_prio(3, 8'h40); set_prio(5, 8'h40);
    do_set(16'h0028); check_high("R2 tie");
    set_prio(7, 8'h30); do_set(16'h0080); check_high("R2 best");
    // R3 priority equal to mask is hidden
    wr(8'h04, 32'h30); m_mask = 8'h30; check_high("R3 equal"); settle("R4 masked");
    wr(8'h04, 32'h31); m_mask = 8'h31; check_high("R3 below"); settle("R4 unmasked");
    do_ack("R6 ack7");
    rd(8'h14, got); chk("R6 runp", got, 8'h30);
    wr(8'h04, 32'hFF); m_mask = 8'hFF; check_high("R3 high"); settle("R4 no preempt");
    // build a 3-deep chain: 7 -> 9 -> 2
    set_prio(9, 8'h10); do_set(16'h0200); do_ack("R6 ack9");
    set_prio(2, 8'h08); do_set(16'h0004); do_ack("R6 ack2");
    do_ack("R6 none");
    do_eoi(9, "R9 splice");
    do_eoi(2, "R8 pop");
    do_eoi(9, "R9 absent");
    do_eoi(20, "R7 range");
    do_eoi(1023, "R7 spurious");
    do_eoi(7, "R8 idle");
    do_eoi(7, "R7 idle");
    // R5 enables
    wr(8'h00, 32'h1); m_ctrl = 1; check_high("R5 ctrl1"); settle("R5 irq");
    do_ack("R5 ack");
    wr(8'h00, 32'h2); m_ctrl = 2; check_high("R5 ctrl2"); settle("R5 irq2");
    wr(8'h00, 32'h3); m_ctrl = 3; check_high("R5 on");
    // R10 disabled source keeps pending
    src_en[3] = 1'b0; check_high("R10 disabled"); settle("R10 irq");
    src_en[3] = 1'b1; check_high("R10 kept");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom_range(0, 9));
      case (op)
        0, 1: do_set(N'($urandom) & N'($urandom));
        2, 3: do_ack("R6 rand");
        4, 5: begin
          int id;
          if (stk.size() > 0 && $urandom_range(0, 3) != 0)
            id = stk[$urandom_range(0, stk.size() - 1)];
          else if ($urandom_range(0, 4) == 0) id = 1023;
          else id = int'($urandom_range(0, N + 3));
          do_eoi(id, "R9 rand");
        end
        6: check_high("R2 rand");
        7: begin
          int i = int'($urandom_range(0, N - 1));
          if (!in_stk(i)) set_prio(i, int'($urandom_range(0, 255)));
          src_en[$urandom_range(0, N - 1)] = 1'($urandom);
          settle("R4 rand");
        end
        8: begin
          m_mask = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255)) : 255;
          wr(8'h04, 32'(m_mask)); settle("R3 rand");
        end
        default: begin
          m_ctrl = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 3)) : 3;
          wr(8'h00, 32'(m_ctrl)); settle("R5 rand");
        end
      endcase
    end
    rd(8'h14, got); chk("R8 final", got, m_rp);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule